// File: doc/BRIEF.md
# DRAM refresh and self-refresh scheduler

This block is the refresh engine of an asynchronous DRAM controller. It runs from the controller clock and drives the row strobe, column strobe and write enable of the DRAM only while it holds the bus. Every cycle it issues is a CAS-before-RAS refresh, so the device's internal row counter supplies the row and no address logic is needed here. All timing limits are parameters counted in clock cycles.

After reset it waits out the power-up pause and then issues a fixed number of back-to-back wake-up refresh cycles on its own. Only then does it raise `ready` to tell the rest of the controller that normal access may begin. From then on an interval timer adds one refresh to a small saturating backlog each time it expires. While the backlog is non-empty and the scheduler is idle, it raises a request to the access arbiter. The cycle starts once the arbiter grants it.

A sleep request sends the DRAM into self refresh. The scheduler opens a refresh cycle and holds both strobes low. It acknowledges the sleep once the row strobe has been low for the minimum self-refresh time. When the request drops, it returns both strobes high for the extended exit precharge. Periodic refresh is distributed, so no burst follows the exit: the backlog is discarded on entry and the interval timer restarts from zero on return.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is applied and for INIT_WAIT cycles after it is released, `ras_n` and `cas_n` are high and `ready`, `ref_req` and `sleep_ack` are low; the first column-strobe fall comes INIT_WAIT cycles after release.
- R2: After the pause, WAKE_CYCLES refresh cycles run back to back without any grant; `ready` rises in the cycle after the last precharge and then stays high.
- R3: A refresh cycle drives `cas_n` low for T_CSR cycles with `ras_n` high, then both low for T_CHR cycles, then `ras_n` alone low, so that `ras_n` is low for T_RAS cycles in total.
- R4: Each normal refresh cycle ends with both strobes high for T_RP cycles before the scheduler goes idle or starts the next cycle.
- R5: `we_n` is high at all times.
- R6: Once `ready` is high and the scheduler is not in self refresh, the backlog grows by one every REF_INTERVAL cycles; `ref_req` is high exactly when the scheduler is idle and the backlog is non-zero.
- R7: When `ref_req` and `ref_gnt` are both high at a clock edge, the refresh cycle starts at that edge, `ref_req` drops, and the backlog falls by one. A timer expiry and a grant at the same edge leave the backlog unchanged.
- R8: The backlog saturates at PEND_MAX. Further expiries are dropped, so after a long ungranted stretch exactly PEND_MAX refreshes are owed.
- R9: If `ref_gnt` and `sleep_req` are high at the same idle edge, a normal refresh cycle runs (its `ras_n`-low, `cas_n`-high phase appears) before self refresh is entered.
- R10: With `sleep_req` high and no grant, an idle scheduler drives `cas_n` low for T_CSR cycles and then holds both strobes low. `sleep_ack` rises in the T_RASS-th cycle of `ras_n` low and stays high while `sleep_req` stays high.
- R11: When `sleep_req` is low while `sleep_ack` is high, both strobes go high at that edge and stay high for T_RPS cycles; `ref_req` stays low during this time.
- R12: Entering self refresh clears the backlog and stops the timer. The timer restarts from zero on return to idle, so `ref_req` rises T_RPS + REF_INTERVAL + 1 cycles after the edge that sees `sleep_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Arbiter grants the bus to a pending refresh |
| sleep_req | input | 1 | Request to enter and remain in self refresh |
| ref_req | output | 1 | A refresh is owed and the scheduler is idle |
| sleep_ack | output | 1 | Self refresh is established |
| ready | output | 1 | Power-up and wake-up sequence finished |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
The scheduler is run with the grant held high, so each request is served at once and the cycle spacing follows the interval timer alone. It is then run with the grant held low over several intervals, which shows whether the backlog saturates or wraps, and released afterwards so the owed cycles can be counted. A sleep entered with a non-zero backlog, followed by the exit, tells a cleared backlog and a restarted timer apart from a stale one. A grant and a sleep request arriving in the same cycle check the priority between them.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        ST_PWR,    // power-up pause
        ST_IDLE,   // bus released
        ST_LEAD,   // column strobe low ahead of the row strobe
        ST_HOLD,   // both strobes low
        ST_RONLY,  // row strobe alone low
        ST_PRE,    // precharge
        ST_SELF,   // self refresh held
        ST_EXIT    // extended precharge after self refresh
    } rf_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    function automatic strobe_t strobe_of(rf_state_e s);
        strobe_t st;
        st.we_n  = 1'b1;
        st.ras_n = !(s == ST_HOLD || s == ST_RONLY || s == ST_SELF);
        st.cas_n = !(s == ST_LEAD || s == ST_HOLD || s == ST_SELF);
        return st;
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rf_interval_timer.sv
module rf_interval_timer #(
    parameter int REF_INTERVAL = 1950
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int TW = $clog2(REF_INTERVAL + 1);
    localparam logic [TW-1:0] LIM = TW'(REF_INTERVAL - 1);

    logic [TW-1:0] cnt_q;

    assign tick = run && (cnt_q == LIM);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && REF_INTERVAL > 1) |=> !tick);

endmodule

// File: rtl/rf_pending_ctr.sv
module rf_pending_ctr #(
    parameter int PEND_MAX = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic inc,
    input  logic dec,
    output logic pend_nz
);
    localparam int PW = $clog2(PEND_MAX + 1);
    localparam logic [PW-1:0] CAP = PW'(PEND_MAX);

    logic [PW-1:0] pend_q;

    assign pend_nz = (pend_q != '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pend_q <= '0;
        end else if (inc && !dec) begin
            if (pend_q != CAP) pend_q <= pend_q + 1'b1;
        end else if (dec && !inc) begin
            pend_q <= pend_q - 1'b1;
        end
    end

    // R8
    pend_cap_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q <= CAP);
    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        dec |-> pend_nz);
    // R12
    sleep_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> !pend_nz);

endmodule

// File: rtl/rf_cbr_seq.sv
module rf_cbr_seq
    import dram_rfsh_pkg::*;
#(
    parameter int INIT_WAIT   = 12500,
    parameter int WAKE_CYCLES = 8,
    parameter int T_CSR       = 1,
    parameter int T_CHR       = 2,
    parameter int T_RAS       = 8,
    parameter int T_RP        = 5,
    parameter int T_RASS      = 12500,
    parameter int T_RPS       = 14
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    pend_nz,
    input  logic    ref_gnt,
    input  logic    sleep_req,
    output logic    ref_req,
    output logic    take,
    output logic    sleep_ack,
    output logic    ready,
    output logic    in_sleep,
    output strobe_t strobe
);
    localparam int CMAX = max_of(max_of(max_of(INIT_WAIT, T_RASS), max_of(T_RAS, T_RP)),
                                 max_of(max_of(T_CSR, T_CHR), T_RPS));
    localparam int CW = $clog2(CMAX + 1);
    localparam int WW = $clog2(WAKE_CYCLES + 1);

    localparam logic [CW-1:0] LIM_INIT = CW'(INIT_WAIT - 1);
    localparam logic [CW-1:0] LIM_CSR  = CW'(T_CSR - 1);
    localparam logic [CW-1:0] LIM_CHR  = CW'(T_CHR - 1);
    localparam logic [CW-1:0] LIM_RON  = CW'(T_RAS - T_CHR - 1);
    localparam logic [CW-1:0] LIM_RP   = CW'(T_RP - 1);
    localparam logic [CW-1:0] LIM_RASS = CW'(T_RASS - 1);
    localparam logic [CW-1:0] LIM_RPS  = CW'(T_RPS - 1);
    localparam logic [WW-1:0] LIM_WAKE = WW'(WAKE_CYCLES - 1);

    rf_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [WW-1:0] wake_q, wake_d;
    logic          self_q, self_d;
    logic          ready_q, ready_d;

    assign ref_req   = (state_q == ST_IDLE) && pend_nz;
    assign take      = ref_req && ref_gnt;
    assign sleep_ack = (state_q == ST_SELF) && (cnt_q == LIM_RASS);
    assign in_sleep  = self_q && (state_q == ST_LEAD || state_q == ST_SELF || state_q == ST_EXIT);
    assign ready     = ready_q;
    assign strobe    = strobe_of(state_q);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        wake_d  = wake_q;
        self_d  = self_q;
        ready_d = ready_q;
        unique case (state_q)
            ST_PWR: if (cnt_q == LIM_INIT) begin
                state_d = ST_LEAD; cnt_d = '0; self_d = 1'b0;
            end
            ST_IDLE: begin
                cnt_d = '0;
                if (take) begin
                    state_d = ST_LEAD; self_d = 1'b0;
                end else if (sleep_req) begin
                    state_d = ST_LEAD; self_d = 1'b1;
                end
            end
            ST_LEAD: if (cnt_q == LIM_CSR) begin
                cnt_d   = '0;
                state_d = self_q ? ST_SELF : ST_HOLD;
            end
            ST_HOLD: if (cnt_q == LIM_CHR) begin
                state_d = ST_RONLY; cnt_d = '0;
            end
            ST_RONLY: if (cnt_q == LIM_RON) begin
                state_d = ST_PRE; cnt_d = '0;
            end
            ST_PRE: if (cnt_q == LIM_RP) begin
                cnt_d = '0;
                if (!ready_q && wake_q != LIM_WAKE) begin
                    wake_d  = wake_q + 1'b1;
                    state_d = ST_LEAD;
                end else begin
                    state_d = ST_IDLE;
                    ready_d = 1'b1;
                end
            end
            ST_SELF: if (cnt_q == LIM_RASS) begin
                cnt_d = cnt_q;
                if (!sleep_req) begin
                    state_d = ST_EXIT; cnt_d = '0;
                end
            end
            ST_EXIT: if (cnt_q == LIM_RPS) begin
                state_d = ST_IDLE; cnt_d = '0;
            end
            default: begin
                state_d = ST_PWR; cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PWR;
            cnt_q   <= '0;
            wake_q  <= '0;
            self_q  <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            wake_q  <= wake_d;
            self_q  <= self_d;
            ready_q <= ready_d;
        end
    end

    // R3
    cas_leads_ras_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe.ras_n) |-> $past(!strobe.cas_n));
    // R3
    cas_high_at_ras_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe.ras_n) |-> strobe.cas_n);
    // R10
    ack_strobes_low_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_ack |-> (!strobe.ras_n && !strobe.cas_n));
    // R6
    req_bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> (ready_q && strobe.ras_n && strobe.cas_n));
    // R2
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ready_q |=> ready_q);
    // R7
    grant_starts_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (!strobe.cas_n && strobe.ras_n && !ref_req));
    // R11
    exit_both_high_chk: assert property (@(posedge clk) disable iff (rst)
        (sleep_ack && !sleep_req) |=> (strobe.ras_n && strobe.cas_n && !sleep_ack));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_rfsh_pkg::*;
#(
    parameter int INIT_WAIT    = 12500,
    parameter int WAKE_CYCLES  = 8,
    parameter int REF_INTERVAL = 1950,
    parameter int T_CSR        = 1,
    parameter int T_CHR        = 2,
    parameter int T_RAS        = 8,
    parameter int T_RP         = 5,
    parameter int T_RASS       = 12500,
    parameter int T_RPS        = 14,
    parameter int PEND_MAX     = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_gnt,
    input  logic sleep_req,
    output logic ref_req,
    output logic sleep_ack,
    output logic ready,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    logic    pend_nz, take, in_sleep, tick;
    strobe_t strobe;

    rf_interval_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (ready && !in_sleep),
        .tick (tick)
    );

    rf_pending_ctr #(.PEND_MAX(PEND_MAX)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .clear   (in_sleep),
        .inc     (tick),
        .dec     (take),
        .pend_nz (pend_nz)
    );

    rf_cbr_seq #(
        .INIT_WAIT   (INIT_WAIT),
        .WAKE_CYCLES (WAKE_CYCLES),
        .T_CSR       (T_CSR),
        .T_CHR       (T_CHR),
        .T_RAS       (T_RAS),
        .T_RP        (T_RP),
        .T_RASS      (T_RASS),
        .T_RPS       (T_RPS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .pend_nz   (pend_nz),
        .ref_gnt   (ref_gnt),
        .sleep_req (sleep_req),
        .ref_req   (ref_req),
        .take      (take),
        .sleep_ack (sleep_ack),
        .ready     (ready),
        .in_sleep  (in_sleep),
        .strobe    (strobe)
    );

    assign ras_n = strobe.ras_n;
    assign cas_n = strobe.cas_n;
    assign we_n  = strobe.we_n;

endmodule

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
    localparam int P_INIT = 20, P_WAKE = 8, P_RI = 40, P_CSR = 2, P_CHR = 2;
    localparam int P_RAS = 6, P_RP = 4, P_RASS = 15, P_RPS = 5, P_PMAX = 3;

    logic clk = 1'b0, rst = 1'b1, ref_gnt = 1'b0, sleep_req = 1'b0;
    logic ref_req, sleep_ack, ready, ras_n, cas_n, we_n;

    always #4 clk = ~clk;

    dram_refresh_sched #(
        .INIT_WAIT(P_INIT), .WAKE_CYCLES(P_WAKE), .REF_INTERVAL(P_RI),
        .T_CSR(P_CSR), .T_CHR(P_CHR), .T_RAS(P_RAS), .T_RP(P_RP),
        .T_RASS(P_RASS), .T_RPS(P_RPS), .PEND_MAX(P_PMAX)
    ) u_dram_refresh_sched (
        .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .sleep_req(sleep_req),
        .ref_req(ref_req), .sleep_ack(sleep_ack), .ready(ready),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    int checks = 0, failures = 0;
    bit cmp_on = 0, done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase name, cycles left in phase, backlog, timer.
    localparam int M_PWR = 0, M_IDLE = 1, M_LEAD = 2, M_HOLD = 3;
    localparam int M_RONLY = 4, M_PRE = 5, M_SELF = 6, M_EXIT = 7;
    int m_ph, m_left, m_wakes, m_pend, m_tmr, m_selfcnt;
    bit m_rdy, m_selfm;
    int d_falls = 0, m_falls = 0;
    bit d_prev = 1, m_prev = 1;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = M_PWR; m_left = P_INIT; m_wakes = 1; m_rdy = 0;
            m_pend = 0; m_tmr = 0; m_selfm = 0; m_selfcnt = 0;
        end else begin
            bit sleeping, run, tick, take;
            sleeping = m_selfm && (m_ph == M_LEAD || m_ph == M_SELF || m_ph == M_EXIT);
            run  = m_rdy && !sleeping;
            tick = run && (m_tmr == P_RI - 1);
            take = (m_ph == M_IDLE) && (m_pend > 0) && ref_gnt;
            m_tmr = run ? (m_tmr + 1) % P_RI : 0;
            if (sleeping) m_pend = 0;
            else if (tick && !take && m_pend < P_PMAX) m_pend++;
            else if (take && !tick) m_pend--;
            case (m_ph)
                M_PWR:  if (m_left == 1) begin m_ph = M_LEAD; m_left = P_CSR; m_selfm = 0; end
                        else m_left--;
                M_IDLE: if (take) begin m_ph = M_LEAD; m_left = P_CSR; m_selfm = 0; end
                        else if (sleep_req) begin m_ph = M_LEAD; m_left = P_CSR; m_selfm = 1; end
                M_LEAD: if (m_left == 1) begin
                            if (m_selfm) begin m_ph = M_SELF; m_selfcnt = 1; end
                            else begin m_ph = M_HOLD; m_left = P_CHR; end
                        end else m_left--;
                M_HOLD: if (m_left == 1) begin m_ph = M_RONLY; m_left = P_RAS - P_CHR; end
                        else m_left--;
                M_RONLY: if (m_left == 1) begin m_ph = M_PRE; m_left = P_RP; end
                        else m_left--;
                M_PRE:  if (m_left == 1) begin
                            if (!m_rdy && m_wakes < P_WAKE) begin
                                m_wakes++; m_ph = M_LEAD; m_left = P_CSR;
                            end else begin m_ph = M_IDLE; m_rdy = 1; end
                        end else m_left--;
                M_SELF: if (m_selfcnt >= P_RASS && !sleep_req) begin m_ph = M_EXIT; m_left = P_RPS; end
                        else if (m_selfcnt < P_RASS) m_selfcnt++;
                M_EXIT: if (m_left == 1) m_ph = M_IDLE;
                        else m_left--;
                default: m_ph = M_PWR;
            endcase
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            bit e_ras, e_cas, e_req, e_ack;
            e_ras = !(m_ph == M_HOLD || m_ph == M_RONLY || m_ph == M_SELF);
            e_cas = !(m_ph == M_LEAD || m_ph == M_HOLD || m_ph == M_SELF);
            e_req = (m_ph == M_IDLE) && (m_pend > 0);
            e_ack = (m_ph == M_SELF) && (m_selfcnt >= P_RASS);
            chk(ras_n === e_ras, "R3/R4/R11 ras_n", int'(ras_n), int'(e_ras));
            chk(cas_n === e_cas, "R3/R4/R10 cas_n", int'(cas_n), int'(e_cas));
            chk(we_n === 1'b1, "R5 we_n", int'(we_n), 1);
            chk(ref_req === e_req, "R6/R7/R8/R12 ref_req", int'(ref_req), int'(e_req));
            chk(sleep_ack === e_ack, "R10 sleep_ack", int'(sleep_ack), int'(e_ack));
            chk(ready === m_rdy, "R1/R2 ready", int'(ready), int'(m_rdy));
            if (d_prev && !ras_n) d_falls++;
            if (m_prev && !e_ras) m_falls++;
            d_prev = ras_n;
            m_prev = e_ras;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        @(negedge clk);
        cmp_on = 1;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk(ras_n && cas_n && !ready && !ref_req && !sleep_ack, "R1 reset state",
            int'({ras_n, cas_n, ready, ref_req, sleep_ack}), 5'b11000);
        rst = 0;
        n = 0;
        do begin @(negedge clk); n++; end while (cas_n);
        chk(n == P_INIT, "R1 pause length", n, P_INIT);

        // R2: wake-up burst
        while (!ready) @(negedge clk);
        chk(d_falls == P_WAKE, "R2 wake-up cycles", d_falls, P_WAKE);

        // R7: grant held high
        ref_gnt = 1;
        repeat (200) @(negedge clk);
        chk(d_falls == m_falls, "R7 refreshes with grant held", d_falls, m_falls);

        // R8: grant withheld past saturation, then released
        ref_gnt = 0;
        repeat (200) @(negedge clk);
        chk(ref_req == 1'b1, "R8 backlog owed", int'(ref_req), 1);
        n = d_falls;
        ref_gnt = 1;
        repeat (3 * (P_CSR + P_RAS + P_RP)) @(negedge clk);
        chk(d_falls - n == P_PMAX, "R8 backlog drained", d_falls - n, P_PMAX);
        ref_gnt = 0;

        // R10: enter self refresh with a backlog building
        sleep_req = 1;
        repeat (60) @(negedge clk);
        chk(sleep_ack == 1'b1 && ras_n == 1'b0 && cas_n == 1'b0, "R10 self refresh held",
            int'({sleep_ack, ras_n, cas_n}), 3'b100);

        // R11 R12: exit and timer restart
        sleep_req = 0;
        n = 0;
        do begin @(negedge clk); n++; end while (!ref_req);
        chk(n == 1 + P_RPS + P_RI, "R11/R12 first request after exit", n, 1 + P_RPS + P_RI);

        // R9: grant and sleep together
        while (!ref_req) @(negedge clk);
        ref_gnt = 1;
        sleep_req = 1;
        repeat (P_CSR + P_CHR + 1) @(negedge clk);
        chk(ras_n == 1'b0 && cas_n == 1'b1, "R9 normal cycle first",
            int'({ras_n, cas_n}), 2'b01);
        repeat (40) @(negedge clk);
        chk(sleep_ack == 1'b1, "R9 self refresh after cycle", int'(sleep_ack), 1);
        sleep_req = 0;
        ref_gnt = 0;
        repeat (60) @(negedge clk);
        chk(d_falls == m_falls, "R3 total row strobe falls", d_falls, m_falls);

        done = 1;
        summary();
        $finish;
    end
endmodule